// File: doc/BRIEF.md
# Accumulator ALU with flags

This is a purely combinational byte-wide arithmetic and logic unit for the execute stage of an accumulator-based microcontroller core. Every cycle the datapath presents the accumulator, a second operand byte that has already been fetched, the B register, the carry and half-carry flags, and a 5-bit operation code. The block returns the next accumulator and B values and the next carry (CY), half-carry (AC) and overflow (OV) values. Each of these five results comes with its own write strobe, so the register file commits only what the operation really changes.

The unit covers these operations:
- binary add, with or without carry-in
- subtract with borrow
- increment and decrement
- bitwise AND, OR and XOR
- clear and complement
- plain rotates and rotates through carry
- nibble exchange
- unsigned 8x8 multiply
- unsigned 8/8 divide
- decimal correction after a BCD addition

When a result is not written, its output simply passes the matching input through, so a bypass path can take the outputs unconditionally.

Top module: `acc_alu`

## Requirements
- R1: For op 0 (add) and op 1 (add with carry), acc_o = (A + X + c) mod 256. Here c is 0 for op 0, whatever cy_i is, and cy_i for op 1. cy_o is the carry out of bit 7, ac_o is the carry out of bit 3, and ov_o is set when the two's-complement sum lies outside -128..127. All three flag strobes and acc_we_o are 1.
- R2: For op 2 (subtract with borrow), acc_o = (A - X - cy_i) mod 256. cy_o is the borrow out of bit 7, ac_o is the borrow out of bit 3, and ov_o flags a signed result outside -128..127. All flag strobes and acc_we_o are 1.
- R3: Op 3 writes (A + 1) mod 256 and op 4 writes (A - 1) mod 256. Neither raises any flag strobe.
- R4: Ops 5, 6 and 7 write A AND X, A OR X and A XOR X. Op 8 writes 0 and op 9 writes the bitwise inverse of A. None of these raises a flag strobe.
- R5: Op 10 rotates A left (bit 7 goes to bit 0), op 12 rotates it right (bit 0 goes to bit 7), and op 14 exchanges the upper and lower nibbles. None of these raises a flag strobe.
- R6: Op 11 rotates left through carry: bit 7 goes to cy_o and cy_i goes to bit 0. Op 13 rotates right through carry: bit 0 goes to cy_o and cy_i goes to bit 7. Only the CY strobe is raised among the flags.
- R7: Op 15 writes the low byte of the unsigned product A*B to acc_o and the high byte to b_o. It writes CY = 0 and OV = 1 exactly when the product exceeds 255. AC is not written.
- R8: Op 16 with B != 0 writes the quotient A/B to acc_o and the remainder A mod B to b_o, and writes CY = 0 and OV = 0.
- R9: Op 16 with B = 0 writes OV = 1 and CY = 0. The acc_o and b_o values are unspecified in this case.
- R10: Op 17 first adds 6 when A[3:0] > 9 or AC = 1. It then adds 0x60 when the upper nibble of that intermediate is above 9, or CY = 1, or the first step carried out of bit 7. cy_o is cy_i OR any carry out of bit 7 from either step. Only the CY strobe is raised among the flags.
- R11: Codes 18..31 are reserved. They raise no write strobe, and acc_o = A, b_o = B, cy_o = cy_i, ac_o = ac_i, ov_o = 0. The same pass-through values appear on every unstrobed output for all ops.
- R12: b_we_o is 1 only for ops 15 and 16. For every other op, b_o equals b_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand byte |
| b_i | input | 8 | Current B register |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current half-carry flag |
| acc_o | output | 8 | Next accumulator |
| acc_we_o | output | 1 | Accumulator write strobe |
| b_o | output | 8 | Next B register |
| b_we_o | output | 1 | B write strobe |
| cy_o | output | 1 | Next carry flag |
| cy_we_o | output | 1 | Carry write strobe |
| ac_o | output | 1 | Next half-carry flag |
| ac_we_o | output | 1 | Half-carry write strobe |
| ov_o | output | 1 | Next overflow flag |
| ov_we_o | output | 1 | Overflow write strobe |

## Verification
The hardest cases to reach are the decimal correction paths in which the low-nibble fix alone carries out of bit 7, and the signed-overflow boundaries of subtract with borrow when a borrow-in is present. A few hand-picked vectors rarely hit these. The bench therefore sweeps both data bytes completely for add, add with carry, subtract with borrow, multiply and divide, with the carry-in tied to a data-dependent bit so that both values occur across the space. It also sweeps every accumulator value against all four CY/AC combinations for the decimal correction and the through-carry rotates.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_CLR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_RL   = 5'd10,
    OP_RLC  = 5'd11,
    OP_RR   = 5'd12,
    OP_RRC  = 5'd13,
    OP_SWAP = 5'd14,
    OP_MUL  = 5'd15,
    OP_DIV  = 5'd16,
    OP_DA   = 5'd17
  } alu_op_e;
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic              cy_i,
  input  logic              sub_i,
  input  logic              use_cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] xo;
  logic              cin;
  logic [DATA_W:0]   full_sum;
  logic [NIB_W:0]    low_sum;
  logic [DATA_W-1:0] top_sum;

  // subtract as A + ~X + ~borrow; carries are inverted into borrows
  always_comb begin
    xo       = sub_i ? ~x_i : x_i;
    cin      = sub_i ? ~(use_cy_i & cy_i) : (use_cy_i & cy_i);
    full_sum = {1'b0, a_i} + {1'b0, xo} + {{DATA_W{1'b0}}, cin};
    low_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, xo[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    top_sum  = {1'b0, a_i[DATA_W-2:0]} + {1'b0, xo[DATA_W-2:0]} + {{(DATA_W-1){1'b0}}, cin};
    res_o    = full_sum[DATA_W-1:0];
    cy_o     = full_sum[DATA_W] ^ sub_i;
    ac_o     = low_sum[NIB_W] ^ sub_i;
    ov_o     = full_sum[DATA_W] ^ top_sum[DATA_W-1];
  end

  always_comb begin
    if (!sub_i && !(use_cy_i && cy_i))
      AST_ADD_NO_CIN_CY: assert (cy_o == (res_o < a_i)); // R1
  end
endmodule

// File: rtl/acc_shift_logic.sv
module acc_shift_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  localparam int NIB_W = DATA_W / 2;

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (op_i)
      OP_AND:  res_o = a_i & x_i;
      OP_OR:   res_o = a_i | x_i;
      OP_XOR:  res_o = a_i ^ x_i;
      OP_CLR:  res_o = '0;
      OP_CPL:  res_o = ~a_i;
      OP_RL:   res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
      OP_RR:   res_o = {a_i[0], a_i[DATA_W-1:1]};
      OP_RLC: begin
        res_o = {a_i[DATA_W-2:0], cy_i};
        cy_o  = a_i[DATA_W-1];
      end
      OP_RRC: begin
        res_o = {cy_i, a_i[DATA_W-1:1]};
        cy_o  = a_i[0];
      end
      OP_SWAP: res_o = {a_i[NIB_W-1:0], a_i[DATA_W-1:NIB_W]};
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == OP_RL || op_i == OP_RR)
      AST_ROT_KEEPS_ONES: assert ($countones(res_o) == $countones(a_i)); // R5
  end
endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] prod_lo_o,
  output logic [DATA_W-1:0] prod_hi_o,
  output logic [DATA_W-1:0] quot_o,
  output logic [DATA_W-1:0] rem_o
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] prod;
  logic [DATA_W:0]   trial;
  logic [DATA_W-1:0] rem;

  always_comb begin
    prod      = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
    prod_lo_o = prod[DATA_W-1:0];
    prod_hi_o = prod[PROD_W-1:DATA_W];
  end

  // restoring division, one quotient bit per unrolled step
  always_comb begin
    rem    = '0;
    quot_o = '0;
    trial  = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      trial = {rem, a_i[i]};
      if (trial >= {1'b0, b_i}) begin
        trial     = trial - {1'b0, b_i};
        quot_o[i] = 1'b1;
      end
      rem = trial[DATA_W-1:0];
    end
    rem_o = rem;
  end
endmodule

// File: rtl/acc_dadj.sv
module acc_dadj #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              cy_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [DATA_W:0] LO_FIX = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HI_FIX = (DATA_W+1)'(6) << NIB_W;

  logic [DATA_W:0] step1;
  logic [DATA_W:0] step2;
  logic            cy_mid;

  always_comb begin
    step1  = {1'b0, a_i} + ((a_i[NIB_W-1:0] > NIB_W'(9) || ac_i) ? LO_FIX : '0);
    cy_mid = cy_i | step1[DATA_W];
    step2  = {1'b0, step1[DATA_W-1:0]}
           + ((step1[DATA_W-1:NIB_W] > NIB_W'(9) || cy_mid) ? HI_FIX : '0);
    res_o  = step2[DATA_W-1:0];
    cy_o   = cy_mid | step2[DATA_W];
  end

  always_comb begin
    if (cy_i) AST_DA_CY_STICKY: assert (cy_o); // R10
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              acc_we_o,
  output logic [DATA_W-1:0] b_o,
  output logic              b_we_o,
  output logic              cy_o,
  output logic              cy_we_o,
  output logic              ac_o,
  output logic              ac_we_o,
  output logic              ov_o,
  output logic              ov_we_o
);
  localparam int PROD_W = 2 * DATA_W;

  alu_op_e           op;
  logic [DATA_W-1:0] as_res, sl_res, mul_lo, mul_hi, quot, rem, da_res;
  logic              as_cy, as_ac, as_ov, sl_cy, da_cy;

  assign op = alu_op_e'(op_i);

  acc_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a_i(acc_i), .x_i(opnd_i), .cy_i(cy_i),
    .sub_i(op == OP_SUBB), .use_cy_i(op != OP_ADD),
    .res_o(as_res), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
  );

  acc_shift_logic #(.DATA_W(DATA_W)) i_shift_logic (
    .op_i(op), .a_i(acc_i), .x_i(opnd_i), .cy_i(cy_i),
    .res_o(sl_res), .cy_o(sl_cy)
  );

  acc_muldiv #(.DATA_W(DATA_W)) i_muldiv (
    .a_i(acc_i), .b_i(b_i),
    .prod_lo_o(mul_lo), .prod_hi_o(mul_hi), .quot_o(quot), .rem_o(rem)
  );

  acc_dadj #(.DATA_W(DATA_W)) i_dadj (
    .a_i(acc_i), .cy_i(cy_i), .ac_i(ac_i), .res_o(da_res), .cy_o(da_cy)
  );

  always_comb begin
    acc_o    = acc_i;  acc_we_o = 1'b0;
    b_o      = b_i;    b_we_o   = 1'b0;
    cy_o     = cy_i;   cy_we_o  = 1'b0;
    ac_o     = ac_i;   ac_we_o  = 1'b0;
    ov_o     = 1'b0;   ov_we_o  = 1'b0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        acc_o = as_res; acc_we_o = 1'b1;
        cy_o  = as_cy;  cy_we_o  = 1'b1;
        ac_o  = as_ac;  ac_we_o  = 1'b1;
        ov_o  = as_ov;  ov_we_o  = 1'b1;
      end
      OP_INC: begin acc_o = acc_i + DATA_W'(1); acc_we_o = 1'b1; end
      OP_DEC: begin acc_o = acc_i - DATA_W'(1); acc_we_o = 1'b1; end
      OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL, OP_RL, OP_RR, OP_SWAP: begin
        acc_o = sl_res; acc_we_o = 1'b1;
      end
      OP_RLC, OP_RRC: begin
        acc_o = sl_res; acc_we_o = 1'b1;
        cy_o  = sl_cy;  cy_we_o  = 1'b1;
      end
      OP_MUL: begin
        acc_o = mul_lo;      acc_we_o = 1'b1;
        b_o   = mul_hi;      b_we_o   = 1'b1;
        cy_o  = 1'b0;        cy_we_o  = 1'b1;
        ov_o  = |mul_hi;     ov_we_o  = 1'b1;
      end
      OP_DIV: begin
        acc_o = quot;        acc_we_o = 1'b1;
        b_o   = rem;         b_we_o   = 1'b1;
        cy_o  = 1'b0;        cy_we_o  = 1'b1;
        ov_o  = (b_i == '0); ov_we_o  = 1'b1;
      end
      OP_DA: begin
        acc_o = da_res; acc_we_o = 1'b1;
        cy_o  = da_cy;  cy_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == 5'd15) begin
      AST_MUL_CY_CLR: assert (cy_we_o && !cy_o); // R7
      AST_MUL_OV_HI: assert (ov_o == (b_o != '0)); // R7
    end
    if (op_i == 5'd16 && b_i != '0) begin
      AST_DIV_IDENT: assert ((PROD_W'(acc_o) * PROD_W'(b_i) + PROD_W'(b_o)) == PROD_W'(acc_i)); // R8
      AST_DIV_REM_LT: assert (b_o < b_i); // R8
    end
    if (op_i == 5'd16 && b_i == '0)
      AST_DIV_ZERO_OV: assert (ov_we_o && ov_o && !cy_o); // R9
    if (op_i == 5'd10 || op_i == 5'd12 || op_i == 5'd14)
      AST_ROT_NO_FLAGS: assert (!cy_we_o && !ac_we_o && !ov_we_o); // R5
    if (op_i > 5'd17)
      AST_RSVD_IDLE: assert (!acc_we_o && !b_we_o && !cy_we_o && !ac_we_o && !ov_we_o); // R11
    if (op_i != 5'd15 && op_i != 5'd16)
      AST_B_ONLY_MULDIV: assert (!b_we_o && b_o == b_i); // R12
  end
endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op;
  logic [7:0] acc, opnd, b;
  logic       cy, ac;
  logic [7:0] acc_o, b_o;
  logic       acc_we, b_we, cy_o, cy_we, ac_o, ac_we, ov_o, ov_we;
  int         n_vec = 0;
  int         n_bad = 0;
  int         cycles = 0;

  always #4 clk = ~clk;

  acc_alu i_acc_alu (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .b_i(b), .cy_i(cy), .ac_i(ac),
    .acc_o(acc_o), .acc_we_o(acc_we), .b_o(b_o), .b_we_o(b_we),
    .cy_o(cy_o), .cy_we_o(cy_we), .ac_o(ac_o), .ac_we_o(ac_we),
    .ov_o(ov_o), .ov_we_o(ov_we)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, got cycles=%0d expected < 200000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // expected = {acc_we, acc, b_we, b, cy_we, cy, ac_we, ac, ov_we, ov}
  task automatic run(input string tag, input int o, input int a, input int x,
                     input int bb, input int ci, input int ai);
    logic [23:0] exp_v, got_v, mask;
    int ea = a, eb = bb, ecy = ci, eac = ai, eov = 0;
    int wa = 0, wb = 0, wc = 0, wh = 0, wo = 0;
    int r, s, cin, t;
    mask = '1;
    case (o)
      0, 1: begin
        cin = (o == 1) ? ci : 0;
        r = a + x + cin; s = sgn(a) + sgn(x) + cin;
        ea = r & 255; ecy = (r > 255); eac = (((a & 15) + (x & 15) + cin) > 15);
        eov = (s > 127 || s < -128); wa = 1; wc = 1; wh = 1; wo = 1;
      end
      2: begin
        r = a - x - ci; s = sgn(a) - sgn(x) - ci;
        ea = r & 255; ecy = (r < 0); eac = (((a & 15) - (x & 15) - ci) < 0);
        eov = (s > 127 || s < -128); wa = 1; wc = 1; wh = 1; wo = 1;
      end
      3: begin ea = (a + 1) & 255; wa = 1; end
      4: begin ea = (a + 255) & 255; wa = 1; end
      5: begin ea = a & x; wa = 1; end
      6: begin ea = a | x; wa = 1; end
      7: begin ea = a ^ x; wa = 1; end
      8: begin ea = 0; wa = 1; end
      9: begin ea = 255 - a; wa = 1; end
      10: begin ea = ((a << 1) | (a >> 7)) & 255; wa = 1; end
      11: begin ea = ((a << 1) | ci) & 255; ecy = a >> 7; wa = 1; wc = 1; end
      12: begin ea = ((a >> 1) | (a << 7)) & 255; wa = 1; end
      13: begin ea = (a >> 1) | (ci << 7); ecy = a & 1; wa = 1; wc = 1; end
      14: begin ea = ((a << 4) | (a >> 4)) & 255; wa = 1; end
      15: begin
        r = a * bb; ea = r & 255; eb = r >> 8; ecy = 0; eov = (r > 255);
        wa = 1; wb = 1; wc = 1; wo = 1;
      end
      16: begin
        wa = 1; wb = 1; wc = 1; wo = 1; ecy = 0;
        if (bb == 0) begin eov = 1; mask[22:15] = '0; mask[13:6] = '0; end
        else begin ea = a / bb; eb = a % bb; eov = 0; end
      end
      17: begin
        t = a;
        if ((a & 15) > 9 || ai) t = t + 6;
        if (t > 255) ecy = 1;
        t = t & 255;
        if ((t >> 4) > 9 || ecy) t = t + 'h60;
        if (t > 255) ecy = 1;
        ea = t & 255; wa = 1; wc = 1;
      end
      default: ;
    endcase
    exp_v = {wa[0], ea[7:0], wb[0], eb[7:0], wc[0], ecy[0], wh[0], eac[0], wo[0], eov[0]};
    op = o[4:0]; acc = a[7:0]; opnd = x[7:0]; b = bb[7:0]; cy = ci[0]; ac = ai[0];
    #1;
    got_v = {acc_we, acc_o, b_we, b_o, cy_we, cy_o, ac_we, ac_o, ov_we, ov_o};
    n_vec = n_vec + 1;
    if ((got_v & mask) != (exp_v & mask)) begin
      n_bad = n_bad + 1;
      $display("FAIL %s op=%0d a=%h x=%h b=%h cy=%0d ac=%0d got=%h expected=%h",
               tag, o, a, x, bb, ci, ai, got_v & mask, exp_v & mask);
    end
    #1;
  endtask

  initial begin
    op = 5'd18; acc = '0; opnd = '0; b = '0; cy = 1'b0; ac = 1'b0;
    #20 rst_n = 1'b1;
    @(negedge clk);
    run("R11", 18, 0, 0, 0, 0, 0);
    for (int a = 0; a < 256; a++)
      for (int x = 0; x < 256; x++) begin
        run("R1", 0, a, x, 0, (a ^ x) & 1, 0);
        run("R1", 1, a, x, 0, (a >> 2 ^ x) & 1, 1);
        run("R2", 2, a, x, 0, (a ^ x >> 1) & 1, 0);
        run("R7", 15, a, 0, x, a & 1, 0);
        run("R8", 16, a, 0, x, 1, 1);
      end
    for (int a = 0; a < 256; a++) begin
      run("R9", 16, a, 0, 0, 1, 0);
      for (int f = 0; f < 4; f++) begin
        run("R3", 3, a, 0, 0, f & 1, f >> 1);
        run("R3", 4, a, 0, 0, f & 1, f >> 1);
        run("R4", 5, a, (a * 37 + f * 91) & 255, 0, f & 1, f >> 1);
        run("R4", 6, a, (a * 53 + f * 17) & 255, 0, f & 1, f >> 1);
        run("R4", 7, a, (a * 29 + f * 77) & 255, 0, f & 1, f >> 1);
        run("R4", 8, a, 0, 0, f & 1, f >> 1);
        run("R4", 9, a, 0, 0, f & 1, f >> 1);
        run("R5", 10, a, 0, 0, f & 1, f >> 1);
        run("R5", 12, a, 0, 0, f & 1, f >> 1);
        run("R5", 14, a, 0, 0, f & 1, f >> 1);
        run("R6", 11, a, 0, 0, f & 1, f >> 1);
        run("R6", 13, a, 0, 0, f & 1, f >> 1);
        run("R10", 17, a, 0, 0, f & 1, f >> 1);
        run("R12", f * 3, a, a ^ 8'h5a, (a * 7 + 3) & 255, f & 1, 0);
      end
      for (int o = 18; o < 32; o++)
        run("R11", o, a, 255 - a, (a + o) & 255, a & 1, (a >> 1) & 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule